// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Buffer

This block holds the five national spare bits, Sa4 through Sa8, carried in timeslot 0 of an E1 stream. Within a CRC-4 multiframe of sixteen frames, the eight odd frames carry the service word. The even frames carry the frame alignment word. Frame alignment logic upstream supplies a strobe for each timeslot 0 byte, a flag that marks the service word, and a strobe for the start of a multiframe.

On the receive side, the block collects one spare bit per position from each service word. It collects these bits in a working buffer. When the next multiframe starts, the whole buffer moves into five host-visible bytes, and a receive interrupt flag is raised.

On the transmit side, the host writes five bytes. When a transmit multiframe starts, those bytes are copied into a shadow set, and a transmit interrupt flag is raised. The shadow bits then replace the spare-bit field of each outgoing service word. If the host does not answer the interrupt, the same shadow contents go out again. When timeslot 0 transparency is selected, the outgoing byte passes through untouched.

A small synchronous register port gives the host read access to the receive bytes and the status flags, and read and write access to the transmit bytes. The status flags clear when the host reads them.

Top module: `e1_sa_mfbuf`

## Requirements
- R1: After reset, all receive bytes, all transmit bytes, both interrupt flags and the status register read as zero.
- R2: For the k-th service word after a multiframe start (k = 0..7), spare bit Sa(n) is taken from rx_ts0[8-n] and stored in bit k of the receive byte for Sa(n). This places Sa4 at rx_ts0[4] and Sa8 at rx_ts0[0]; rx_ts0[7] is the first bit on the line. Frames with rx_nfas low contribute nothing.
- R3: The receive bytes change only on a cycle where rx_frame_stb and rx_mf_begin are both high. At that moment they take the complete previous multiframe. A multiframe-start strobe without a frame strobe has no effect.
- R4: The receive and transmit flags are set by their own multiframe-start frames. A host read of the status address clears them. If an event falls in the same cycle as that read, the read returns the old value and the flag remains set.
- R5: A tx_frame_stb with tx_mf_begin copies the five transmit bytes into the shadow set and raises the transmit flag. At no other time does the shadow set change.
- R6: On the k-th outgoing service word, tx_ts0_out equals tx_ts0_in with bits [4:0] replaced by {Sa4..Sa8} shadow bit k. Frames with tx_nfas low pass through unchanged.
- R7: If the host writes nothing, the next multiframe carries the same spare-bit pattern again.
- R8: A host write to a transmit byte in the same cycle as the transmit multiframe start reaches the line only in the following multiframe.
- R9: While tx_ts0_transp is high, tx_ts0_out equals tx_ts0_in.
- R10: The register map is as follows. Addresses 0..4 are the receive bytes Sa4..Sa8, read-only. Addresses 8..12 are the transmit bytes Sa4..Sa8, read and write. Address 15 is status, with bit 0 the receive flag and bit 1 the transmit flag. Every other address reads zero, and writes to addresses other than 8..12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_frame_stb | input | 1 | A received timeslot 0 byte is present |
| rx_nfas | input | 1 | The received byte is a service word |
| rx_mf_begin | input | 1 | The received frame opens a multiframe |
| rx_ts0 | input | 8 | Received timeslot 0 byte, bit 7 first on line |
| tx_frame_stb | input | 1 | An outgoing timeslot 0 byte is present |
| tx_nfas | input | 1 | The outgoing byte is a service word |
| tx_mf_begin | input | 1 | The outgoing frame opens a multiframe |
| tx_ts0_transp | input | 1 | Pass timeslot 0 through without insertion |
| tx_ts0_in | input | 8 | Outgoing timeslot 0 byte before insertion |
| tx_ts0_out | output | 8 | Outgoing timeslot 0 byte after insertion |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, same cycle as the address |
| irq_rx_mf | output | 1 | Receive multiframe flag |
| irq_tx_mf | output | 1 | Transmit multiframe flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a host status read and a multiframe start, which sets a flag while the read clears it. The bench issues the read during the multiframe-start frame itself. It then judges that the returned byte shows the flags as they were before, and that a following read finds them set. The second pair is a host write to a transmit byte and the shadow copy. The bench places that write in the start frame, and expects the outgoing service words to carry the old byte for one multiframe and the new byte in the next.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_NUM_DEF    = 5;
  localparam int SW_NUM_DEF    = 8;
  localparam int TS_W_DEF      = 8;
  localparam int SA_FIRST_DEF  = 4;
  localparam int ADDR_W_DEF    = 4;
  localparam int RX_BASE_DEF   = 0;
  localparam int TX_BASE_DEF   = 8;
  localparam int STAT_ADDR_DEF = 15;
  localparam int STAT_RX_BIT   = 0;
  localparam int STAT_TX_BIT   = 1;

  // Line position p (1 = first sent, MSB) maps to vector index ts_w - p.
  function automatic int sa_pos(int ts_w, int first, int lane);
    return ts_w - (first + lane);
  endfunction

  function automatic logic [31:0] sa_mask(int ts_w, int first, int lanes);
    logic [31:0] m;
    m = '0;
    for (int l = 0; l < lanes; l++) m[sa_pos(ts_w, first, l)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/e1_sa_rst_sync.sv
module e1_sa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/e1_sa_rx_capture.sv
module e1_sa_rx_capture
  import e1_sa_pkg::*;
#(
  parameter int SA_NUM   = SA_NUM_DEF,
  parameter int SW_NUM   = SW_NUM_DEF,
  parameter int TS_W     = TS_W_DEF,
  parameter int SA_FIRST = SA_FIRST_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_stb,
  input  logic                           nfas,
  input  logic                           mf_begin,
  input  logic [TS_W-1:0]                ts0,
  output logic [SA_NUM-1:0][SW_NUM-1:0]  rx_regs,
  output logic                           mf_evt
);
  localparam int CNT_W = $clog2(SW_NUM + 1);
  localparam logic [31:0] MASK32 = sa_mask(TS_W, SA_FIRST, SA_NUM);
  localparam logic [TS_W-1:0] SA_MASK = MASK32[TS_W-1:0];

  logic [CNT_W-1:0]                cnt_q, cnt_d;
  logic [SA_NUM-1:0][SW_NUM-1:0]   acc_q, acc_d;
  logic [SA_NUM-1:0][SW_NUM-1:0]   regs_q;
  logic [SA_NUM-1:0]               lane_bit;
  logic                            in_window;
  logic                            cap;
  logic                            cnt_en;
  logic                            unused_bits;

  genvar l;
  generate
    for (l = 0; l < SA_NUM; l++) begin : g_lane
      localparam int POS = sa_pos(TS_W, SA_FIRST, l);
      assign lane_bit[l] = ts0[POS];
    end
  endgenerate

  assign unused_bits = ^(ts0 & ~SA_MASK);

  assign mf_evt    = frame_stb & mf_begin;
  assign in_window = (cnt_q < CNT_W'(SW_NUM));
  assign cap       = frame_stb & nfas & ~mf_begin & in_window;
  assign cnt_en    = mf_evt | cap;

  always_comb begin
    cnt_d = cnt_q;
    if (mf_evt)   cnt_d = '0;
    else if (cap) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    acc_d = acc_q;
    for (int ln = 0; ln < SA_NUM; ln++) begin
      for (int s = 0; s < SW_NUM; s++) begin
        if (cnt_q == CNT_W'(s)) acc_d[ln][s] = lane_bit[ln];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      regs_q <= '0;
    end else begin
      if (cnt_en) cnt_q  <= cnt_d;
      if (cap)    acc_q  <= acc_d;
      if (mf_evt) regs_q <= acc_q;
    end
  end

  assign rx_regs = regs_q;

  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_evt |=> $stable(rx_regs));
endmodule

// File: rtl/e1_sa_tx_insert.sv
module e1_sa_tx_insert
  import e1_sa_pkg::*;
#(
  parameter int SA_NUM   = SA_NUM_DEF,
  parameter int SW_NUM   = SW_NUM_DEF,
  parameter int TS_W     = TS_W_DEF,
  parameter int SA_FIRST = SA_FIRST_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_stb,
  input  logic                           nfas,
  input  logic                           mf_begin,
  input  logic                           transp,
  input  logic [TS_W-1:0]                ts0_in,
  input  logic [SA_NUM-1:0][SW_NUM-1:0]  xregs,
  output logic [TS_W-1:0]                ts0_out,
  output logic                           mf_evt
);
  localparam int CNT_W = $clog2(SW_NUM + 1);

  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic [SA_NUM-1:0][SW_NUM-1:0]  shadow_q;
  logic [SA_NUM-1:0]              lane_bits;
  logic                           in_window;
  logic                           adv;
  logic                           cnt_en;
  logic                           insert;

  assign mf_evt    = frame_stb & mf_begin;
  assign in_window = (cnt_q < CNT_W'(SW_NUM));
  assign adv       = frame_stb & nfas & ~mf_begin & in_window;
  assign cnt_en    = mf_evt | adv;
  assign insert    = nfas & ~mf_begin & ~transp & in_window;

  always_comb begin
    cnt_d = cnt_q;
    if (mf_evt)   cnt_d = '0;
    else if (adv) cnt_d = cnt_q + CNT_W'(1);
  end

  genvar l;
  generate
    for (l = 0; l < SA_NUM; l++) begin : g_lane
      always_comb begin
        lane_bits[l] = 1'b0;
        for (int s = 0; s < SW_NUM; s++) begin
          if (cnt_q == CNT_W'(s)) lane_bits[l] = shadow_q[l][s];
        end
      end
    end
  endgenerate

  always_comb begin
    ts0_out = ts0_in;
    if (insert) begin
      for (int ln = 0; ln < SA_NUM; ln++) begin
        ts0_out[sa_pos(TS_W, SA_FIRST, ln)] = lane_bits[ln];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
    end else begin
      if (cnt_en) cnt_q    <= cnt_d;
      if (mf_evt) shadow_q <= xregs;
    end
  end

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_evt |=> $stable(shadow_q));

  // R8
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_evt |=> shadow_q == $past(xregs));

  // R9
  transp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transp |-> ts0_out == ts0_in);
endmodule

// File: rtl/e1_sa_host_regs.sv
module e1_sa_host_regs
  import e1_sa_pkg::*;
#(
  parameter int SA_NUM    = SA_NUM_DEF,
  parameter int DATA_W    = SW_NUM_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int RX_BASE   = RX_BASE_DEF,
  parameter int TX_BASE   = TX_BASE_DEF,
  parameter int STAT_ADDR = STAT_ADDR_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  input  logic [SA_NUM-1:0][DATA_W-1:0]  rx_regs,
  input  logic                           rx_evt,
  input  logic                           tx_evt,
  output logic [SA_NUM-1:0][DATA_W-1:0]  xregs,
  output logic                           irq_rx,
  output logic                           irq_tx
);
  logic [SA_NUM-1:0][DATA_W-1:0]  xregs_q, xregs_d;
  logic [SA_NUM-1:0]              xwr_hit;
  logic                           xwr_en;
  logic                           stat_rd;
  logic                           irq_rx_q, irq_rx_d;
  logic                           irq_tx_q, irq_tx_d;

  genvar l;
  generate
    for (l = 0; l < SA_NUM; l++) begin : g_wdec
      assign xwr_hit[l] = wr && (addr == ADDR_W'(TX_BASE + l));
    end
  endgenerate

  assign xwr_en  = |xwr_hit;
  assign stat_rd = rd && (addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    xregs_d = xregs_q;
    for (int ln = 0; ln < SA_NUM; ln++) begin
      if (xwr_hit[ln]) xregs_d[ln] = wdata;
    end
  end

  // A new event outranks a clear in the same cycle.
  always_comb begin
    irq_rx_d = rx_evt | (irq_rx_q & ~stat_rd);
    irq_tx_d = tx_evt | (irq_tx_q & ~stat_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xregs_q  <= '0;
      irq_rx_q <= 1'b0;
      irq_tx_q <= 1'b0;
    end else begin
      if (xwr_en) xregs_q <= xregs_d;
      irq_rx_q <= irq_rx_d;
      irq_tx_q <= irq_tx_d;
    end
  end

  always_comb begin
    rdata = '0;
    for (int ln = 0; ln < SA_NUM; ln++) begin
      if (addr == ADDR_W'(RX_BASE + ln)) rdata = rx_regs[ln];
      if (addr == ADDR_W'(TX_BASE + ln)) rdata = xregs_q[ln];
    end
    if (addr == ADDR_W'(STAT_ADDR)) begin
      rdata[STAT_RX_BIT] = irq_rx_q;
      rdata[STAT_TX_BIT] = irq_tx_q;
    end
  end

  assign xregs  = xregs_q;
  assign irq_rx = irq_rx_q;
  assign irq_tx = irq_tx_q;

  // R4
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> irq_rx);

  // R4
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> irq_tx);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_evt) |=> !irq_rx);

  // R10
  xreg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(TX_BASE)) |=> xregs[0] == $past(wdata));
endmodule

// File: rtl/e1_sa_mfbuf.sv
module e1_sa_mfbuf
  import e1_sa_pkg::*;
#(
  parameter int SA_NUM    = SA_NUM_DEF,
  parameter int SW_NUM    = SW_NUM_DEF,
  parameter int TS_W      = TS_W_DEF,
  parameter int SA_FIRST  = SA_FIRST_DEF,
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int RX_BASE   = RX_BASE_DEF,
  parameter int TX_BASE   = TX_BASE_DEF,
  parameter int STAT_ADDR = STAT_ADDR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame_stb,
  input  logic              rx_nfas,
  input  logic              rx_mf_begin,
  input  logic [TS_W-1:0]   rx_ts0,
  input  logic              tx_frame_stb,
  input  logic              tx_nfas,
  input  logic              tx_mf_begin,
  input  logic              tx_ts0_transp,
  input  logic [TS_W-1:0]   tx_ts0_in,
  output logic [TS_W-1:0]   tx_ts0_out,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [SW_NUM-1:0] host_wdata,
  output logic [SW_NUM-1:0] host_rdata,
  output logic              irq_rx_mf,
  output logic              irq_tx_mf
);
  logic                           rst_sync_n;
  logic [SA_NUM-1:0][SW_NUM-1:0]  rx_regs;
  logic [SA_NUM-1:0][SW_NUM-1:0]  xregs;
  logic                           rx_evt;
  logic                           tx_evt;

  e1_sa_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  e1_sa_rx_capture #(
    .SA_NUM(SA_NUM), .SW_NUM(SW_NUM), .TS_W(TS_W), .SA_FIRST(SA_FIRST)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (rx_frame_stb),
    .nfas      (rx_nfas),
    .mf_begin  (rx_mf_begin),
    .ts0       (rx_ts0),
    .rx_regs   (rx_regs),
    .mf_evt    (rx_evt)
  );

  e1_sa_tx_insert #(
    .SA_NUM(SA_NUM), .SW_NUM(SW_NUM), .TS_W(TS_W), .SA_FIRST(SA_FIRST)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .frame_stb (tx_frame_stb),
    .nfas      (tx_nfas),
    .mf_begin  (tx_mf_begin),
    .transp    (tx_ts0_transp),
    .ts0_in    (tx_ts0_in),
    .xregs     (xregs),
    .ts0_out   (tx_ts0_out),
    .mf_evt    (tx_evt)
  );

  e1_sa_host_regs #(
    .SA_NUM(SA_NUM), .DATA_W(SW_NUM), .ADDR_W(ADDR_W),
    .RX_BASE(RX_BASE), .TX_BASE(TX_BASE), .STAT_ADDR(STAT_ADDR)
  ) u_host (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (host_wr),
    .rd      (host_rd),
    .addr    (host_addr),
    .wdata   (host_wdata),
    .rdata   (host_rdata),
    .rx_regs (rx_regs),
    .rx_evt  (rx_evt),
    .tx_evt  (tx_evt),
    .xregs   (xregs),
    .irq_rx  (irq_rx_mf),
    .irq_tx  (irq_tx_mf)
  );
endmodule

// File: tb/e1_sa_mfbuf_test.sv
module e1_sa_mfbuf_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;
  // {rx pattern[79:40], tx pattern[39:0]}; each pattern is {Sa4,Sa5,Sa6,Sa7,Sa8} bytes
  localparam logic [79:0] VEC [4] = '{
    80'h018055AA0F3CC300FF81,
    80'hF00F33CC96123456789A,
    80'h7E81A55AFFFF00AA55E7,
    80'h112244880069960FF024
  };

  logic clk = 1'b0;
  logic rst_n;
  logic rx_frame_stb, rx_nfas, rx_mf_begin;
  logic [7:0] rx_ts0;
  logic tx_frame_stb, tx_nfas, tx_mf_begin, tx_ts0_transp;
  logic [7:0] tx_ts0_in, tx_ts0_out;
  logic host_wr, host_rd;
  logic [3:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic irq_rx_mf, irq_tx_mf;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_sa_mfbuf uut (
    .clk(clk), .rst_n(rst_n),
    .rx_frame_stb(rx_frame_stb), .rx_nfas(rx_nfas), .rx_mf_begin(rx_mf_begin), .rx_ts0(rx_ts0),
    .tx_frame_stb(tx_frame_stb), .tx_nfas(tx_nfas), .tx_mf_begin(tx_mf_begin),
    .tx_ts0_transp(tx_ts0_transp), .tx_ts0_in(tx_ts0_in), .tx_ts0_out(tx_ts0_out),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_rx_mf(irq_rx_mf), .irq_tx_mf(irq_tx_mf)
  );

  function automatic logic [4:0] sa_field(logic [39:0] pat, int k);
    return {pat[32+k], pat[24+k], pat[16+k], pat[8+k], pat[k]};
  endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic write_tx(input logic [39:0] pat);
    for (int i = 0; i < 5; i++) host_write(4'(8 + i), pat[8*(4-i) +: 8]);
  endtask

  task automatic check_rx(input string tag, input logic [39:0] exp);
    logic [7:0] d;
    for (int i = 0; i < 5; i++) begin
      host_read(4'(i), d);
      chk(tag, 40'(d), 40'(exp[8*(4-i) +: 8]));
    end
  endtask

  task automatic check_stat(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    host_read(4'd15, d);
    chk(tag, 40'(d), 40'(exp));
  endtask

  // One full multiframe on both sides; frame 0 may also carry a host access.
  task automatic run_mf(input logic [39:0] rx_pat, input logic [39:0] tx_exp,
                        input logic transp, input logic f0_wr, input logic f0_rd,
                        input logic [3:0] f0_addr, input logic [7:0] f0_data,
                        output logic [7:0] f0_rdata);
    logic [7:0] tin, texp;
    f0_rdata = '0;
    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      rx_frame_stb = 1'b1; tx_frame_stb = 1'b1;
      rx_mf_begin = (f == 0); tx_mf_begin = (f == 0);
      rx_nfas = f[0]; tx_nfas = f[0]; tx_ts0_transp = transp;
      if (f[0]) rx_ts0 = {3'b101, sa_field(rx_pat, f >> 1)};
      else      rx_ts0 = {3'b010, ~sa_field(rx_pat, f >> 1)};
      tin = 8'(f * 37 + 5);
      tx_ts0_in = tin;
      texp = (f[0] && !transp) ? {tin[7:5], sa_field(tx_exp, f >> 1)} : tin;
      if (f == 0) begin
        host_wr = f0_wr; host_rd = f0_rd; host_addr = f0_addr; host_wdata = f0_data;
      end
      #1;
      if (transp) chk("R9 transparent byte", 40'(tx_ts0_out), 40'(texp));
      else        chk("R6 tx insertion", 40'(tx_ts0_out), 40'(texp));
      if (f == 0) f0_rdata = host_rdata;
      @(negedge clk);
      rx_frame_stb = 1'b0; tx_frame_stb = 1'b0; rx_mf_begin = 1'b0; tx_mf_begin = 1'b0;
      host_wr = 1'b0; host_rd = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic [39:0] prev_rx;
    rst_n = 1'b0;
    rx_frame_stb = 0; rx_nfas = 0; rx_mf_begin = 0; rx_ts0 = '0;
    tx_frame_stb = 0; tx_nfas = 0; tx_mf_begin = 0; tx_ts0_transp = 0; tx_ts0_in = '0;
    host_wr = 0; host_rd = 0; host_addr = '0; host_wdata = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    check_rx("R1 rx reset", 40'h0);
    for (int i = 0; i < 5; i++) begin
      host_read(4'(8 + i), d);
      chk("R1 tx reset", 40'(d), 40'h0);
    end
    check_stat("R1 status reset", 8'h00);
    chk("R1 irq lines", 40'({irq_tx_mf, irq_rx_mf}), 40'h0);

    // Table walk: R2, R3, R5, R6
    prev_rx = 40'h0;
    for (int p = 0; p < 4; p++) begin
      write_tx(VEC[p][39:0]);
      run_mf(VEC[p][79:40], VEC[p][39:0], 1'b0, 1'b0, 1'b0, 4'd0, 8'd0, d);
      check_rx("R3 rx holds previous multiframe", prev_rx);
      chk("R5 irq lines set", 40'({irq_tx_mf, irq_rx_mf}), 40'h3);
      check_stat("R4 status set", 8'h03);
      check_stat("R4 status cleared by read", 8'h00);
      prev_rx = VEC[p][79:40];
    end

    // R7: no host write, stale pattern repeated; R2 previous multiframe appears
    run_mf(40'hFF00FF00FF, VEC[3][39:0], 1'b0, 1'b0, 1'b0, 4'd0, 8'd0, d);
    check_rx("R2 rx capture", VEC[3][79:40]);
    check_stat("R4 status after stale multiframe", 8'h03);

    // R3: multiframe strobe without frame strobe does nothing
    @(negedge clk);
    rx_mf_begin = 1'b1; tx_mf_begin = 1'b1;
    @(negedge clk);
    rx_mf_begin = 1'b0; tx_mf_begin = 1'b0;
    check_stat("R3 lone strobe sets no flag", 8'h00);
    check_rx("R3 lone strobe leaves rx", VEC[3][79:40]);

    // R8: write in the start frame goes out one multiframe later
    run_mf(40'h0102040810, VEC[3][39:0], 1'b0, 1'b1, 1'b0, 4'd8, 8'hC3, d);
    check_stat("R5 flags after write collision", 8'h03);
    // R4: status read in the start frame returns old flags, flags stay set
    run_mf(40'hA5A5A5A5A5, {8'hC3, VEC[3][31:0]}, 1'b0, 1'b0, 1'b1, 4'd15, 8'd0, d);
    chk("R4 read during event returns old", 40'(d), 40'h0);
    chk("R4 set wins over clear", 40'({irq_tx_mf, irq_rx_mf}), 40'h3);
    check_stat("R4 status after collision", 8'h03);
    check_rx("R2 rx capture second pattern", 40'h0102040810);

    // R9: transparent mode
    run_mf(40'h3C3C3C3C3C, {8'hC3, VEC[3][31:0]}, 1'b1, 1'b0, 1'b0, 4'd0, 8'd0, d);
    check_rx("R2 rx capture during transparency", 40'hA5A5A5A5A5);

    // R10: register map
    host_write(4'd0, 8'hEE);
    host_read(4'd0, d);
    chk("R10 rx byte not writable", 40'(d), 40'hA5);
    check_stat("R10 status clear", 8'h03);
    host_write(4'd15, 8'hFF);
    check_stat("R10 status not writable", 8'h00);
    host_read(4'd5, d);
    chk("R10 unused address", 40'(d), 40'h0);
    host_read(4'd14, d);
    chk("R10 unused address high", 40'(d), 40'h0);
    host_read(4'd8, d);
    chk("R10 tx readback", 40'(d), 40'hC3);
    host_read(4'd12, d);
    chk("R10 tx readback last", 40'(d), 40'(VEC[3][7:0]));

    done = 1'b1;
    finish_run();
  end
endmodule